// File: doc/BRIEF.md
# Datapath Self-Test Controller with Signature

This block exercises the digital back end of a two-channel data converter without the analog core. A one-cycle start pulse launches a run. While the run is active, a 9-bit pseudorandom generator produces one 14-bit word per sample. That word replaces the core output on each selected channel before it enters the digital path: channel A receives the word as it is and channel B receives its bitwise inverse.

The words that come back from the datapath are folded into a 16-bit multiple-input signature register. After a fixed number of folded samples the run stops by itself. Its result can then be read as a low byte and a high byte. The injected stream stays visible on the feed outputs for the whole run, so downstream logic and link capture can watch it.

A mode input selects what happens to the generator at each start. It can be reloaded with its seed, or it can carry on from where the previous run left it. Because of this, the signature depends both on that mode and on which channels take part.

Top module: `dp_bist_ctrl`

## Requirements
- R1: After reset, busy, done and both signature bytes are 0, and feed_a and feed_b equal core_a and core_b.
- R2: A start pulse while busy is 0 sets busy the next cycle, clears done, and clears the whole signature to zero.
- R3: While busy is 0, or for a channel not selected at start, the feed output equals the core input. While busy is 1, a selected channel A carries the current pseudorandom word and a selected channel B carries its bitwise inverse.
- R4: The generator is a 9-bit state s. Each bit step computes b = s[8] XOR s[4] and shifts s left with b entering bit 0. A word is 14 bit steps, and the first bit produced is the word's MSB. The state advances by one word on each cycle with busy and smp_valid both 1.
- R5: At an accepted start with keep_state 0, the state is reloaded to 9'h092. With keep_state 1 it keeps its value from the end of the previous run. Reset also loads 9'h092.
- R6: On each cycle with busy and ret_valid both 1, the signature takes one step per selected channel, channel A first and then channel B. A step shifts the signature left by one, XORs in 16'h1021 when the bit shifted out is 1, then XORs in the 14-bit returned word zero-extended to 16 bits.
- R7: After exactly 512 update cycles, busy falls in the following cycle and done rises. Done stays 1 until the next accepted start.
- R8: A start pulse while busy is 1 is ignored: the run length, the signature and the generator are unaffected.
- R9: sig_lo is signature bits 7:0 and sig_hi is bits 15:8. Both hold their values while busy is 0 until the next accepted start.
- R10: chan_sel bit 0 selects channel A and bit 1 selects channel B. It is sampled at an accepted start, and changes during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request pulse |
| keep_state | input | 1 | 1: continue generator state, 0: reload seed |
| chan_sel | input | 2 | Channel participation, bit 0 = A, bit 1 = B |
| smp_valid | input | 1 | Sample strobe into the datapath |
| core_a | input | 14 | Channel A core output |
| core_b | input | 14 | Channel B core output |
| feed_a | output | 14 | Channel A word into the datapath |
| feed_b | output | 14 | Channel B word into the datapath |
| ret_valid | input | 1 | Datapath result strobe |
| ret_a | input | 14 | Channel A datapath result |
| ret_b | input | 14 | Channel B datapath result |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| sig_lo | output | 8 | Signature bits 7:0 |
| sig_hi | output | 8 | Signature bits 15:8 |

## Verification
The properties assume that start, smp_valid and ret_valid are clean single-bit levels sampled at the clock edge. They also assume that ret_valid eventually arrives often enough to finish a run, because the run-length check only fires when busy falls. The stimulus models the datapath as a two-cycle pipe fed from the block's own feed outputs, with roughly three valid samples in four. It also fires extra start pulses and flips chan_sel in the middle of runs, so the input sequences stay within what a real datapath produces.

// File: rtl/dp_bist_pkg.sv
package dp_bist_pkg;

  // Default geometry of the self-test controller
  localparam int unsigned DEF_DATA_W  = 14;
  localparam int unsigned DEF_SIG_W   = 16;
  localparam int unsigned DEF_LFSR_W  = 9;
  localparam int unsigned DEF_TAP     = 5;
  localparam int unsigned DEF_RUN_LEN = 512;
  localparam logic [15:0] DEF_POLY    = 16'h1021;
  localparam logic [8:0]  DEF_SEED    = 9'h092;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_DONE = 2'd2
  } run_state_t;

endpackage

// File: rtl/bist_pn_src.sv
module bist_pn_src #(
  parameter int unsigned LFSR_W = dp_bist_pkg::DEF_LFSR_W,
  parameter int unsigned DATA_W = dp_bist_pkg::DEF_DATA_W,
  parameter int unsigned TAP    = dp_bist_pkg::DEF_TAP,
  parameter logic [LFSR_W-1:0] SEED = dp_bist_pkg::DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_seed,
  input  logic              advance,
  output logic [DATA_W-1:0] word
);

  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] state_nx;

  // One generator bit step: feedback from MSB and tap
  function automatic logic [LFSR_W-1:0] bit_step(input logic [LFSR_W-1:0] s);
    logic fb;
    fb = s[LFSR_W-1] ^ s[TAP-1];
    return {s[LFSR_W-2:0], fb};
  endfunction

  // Word assembled from DATA_W steps, first bit lands in the MSB
  function automatic logic [DATA_W-1:0] word_of(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    logic [DATA_W-1:0] w;
    t = s;
    w = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      t = bit_step(t);
      w[DATA_W-1-i] = t[0];
    end
    return w;
  endfunction

  function automatic logic [LFSR_W-1:0] state_after_word(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < int'(DATA_W); i++) t = bit_step(t);
    return t;
  endfunction

  always_comb begin
    state_nx = state_q;
    if (load_seed)    state_nx = SEED;
    else if (advance) state_nx = state_after_word(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_nx;
  end

  assign word = word_of(state_q);

endmodule

// File: rtl/bist_misr.sv
module bist_misr #(
  parameter int unsigned SIG_W  = dp_bist_pkg::DEF_SIG_W,
  parameter int unsigned DATA_W = dp_bist_pkg::DEF_DATA_W,
  parameter logic [SIG_W-1:0] POLY = dp_bist_pkg::DEF_POLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic              use_a,
  input  logic              use_b,
  input  logic [DATA_W-1:0] din_a,
  input  logic [DATA_W-1:0] din_b,
  output logic [SIG_W-1:0]  sig,
  output logic [SIG_W-1:0]  sig_nx
);

  localparam int unsigned PAD_W = SIG_W - DATA_W;

  logic [SIG_W-1:0] sig_q;
  logic [SIG_W-1:0] after_a;
  logic [SIG_W-1:0] after_b;

  // One compression step: shift, conditional polynomial, fold in data
  function automatic logic [SIG_W-1:0] sig_step(input logic [SIG_W-1:0] s,
                                                input logic [DATA_W-1:0] d);
    logic [SIG_W-1:0] sh;
    sh = {s[SIG_W-2:0], 1'b0};
    if (s[SIG_W-1]) sh = sh ^ POLY;
    return sh ^ {{PAD_W{1'b0}}, d};
  endfunction

  assign after_a = use_a ? sig_step(sig_q, din_a)   : sig_q;
  assign after_b = use_b ? sig_step(after_a, din_b) : after_a;

  always_comb begin
    sig_nx = sig_q;
    if (clr)      sig_nx = '0;
    else if (upd) sig_nx = after_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_nx;
  end

  assign sig = sig_q;

endmodule

// File: rtl/bist_seq.sv
module bist_seq
  import dp_bist_pkg::*;
#(
  parameter int unsigned RUN_LEN = DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic upd_req,
  output logic busy,
  output logic done,
  output logic accept,
  output logic upd,
  output logic last_upd
);

  localparam int unsigned CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

  run_state_t       st_q, st_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  assign busy     = (st_q == RS_RUN);
  assign done     = (st_q == RS_DONE);
  assign accept   = start && !busy;
  assign upd      = busy && upd_req;
  assign last_upd = upd && (cnt_q == CNT_LAST);

  always_comb begin
    st_nx  = st_q;
    cnt_nx = cnt_q;
    unique case (st_q)
      RS_IDLE, RS_DONE: begin
        if (accept) begin
          st_nx  = RS_RUN;
          cnt_nx = '0;
        end
      end
      RS_RUN: begin
        if (last_upd) begin
          st_nx  = RS_DONE;
          cnt_nx = '0;
        end else if (upd) begin
          cnt_nx = cnt_q + 1'b1;
        end
      end
      default: st_nx = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nx;
      cnt_q <= cnt_nx;
    end
  end

endmodule

// File: rtl/dp_bist_ctrl.sv
module dp_bist_ctrl
  import dp_bist_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned SIG_W   = DEF_SIG_W,
  parameter int unsigned LFSR_W  = DEF_LFSR_W,
  parameter int unsigned TAP     = DEF_TAP,
  parameter int unsigned RUN_LEN = DEF_RUN_LEN,
  parameter logic [SIG_W-1:0]  POLY = DEF_POLY,
  parameter logic [LFSR_W-1:0] SEED = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              keep_state,
  input  logic [1:0]        chan_sel,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] core_a,
  input  logic [DATA_W-1:0] core_b,
  output logic [DATA_W-1:0] feed_a,
  output logic [DATA_W-1:0] feed_b,
  input  logic              ret_valid,
  input  logic [DATA_W-1:0] ret_a,
  input  logic [DATA_W-1:0] ret_b,
  output logic              busy,
  output logic              done,
  output logic [7:0]        sig_lo,
  output logic [7:0]        sig_hi
);

  localparam int unsigned NCH = 2;

  // Named internal events, visible to the bound checker
  logic              accept;
  logic              upd;
  logic              last_upd;
  logic              load_seed;
  logic              pn_adv;
  logic [NCH-1:0]    sel_q;
  logic [DATA_W-1:0] pn_word;
  logic [SIG_W-1:0]  sig;
  logic [SIG_W-1:0]  sig_nx;

  logic [DATA_W-1:0] core_v [NCH];
  logic [DATA_W-1:0] feed_v [NCH];

  bist_seq #(.RUN_LEN(RUN_LEN)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .upd_req  (ret_valid),
    .busy     (busy),
    .done     (done),
    .accept   (accept),
    .upd      (upd),
    .last_upd (last_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (accept) sel_q <= chan_sel;
  end

  assign load_seed = accept && !keep_state;
  assign pn_adv    = busy && smp_valid;

  bist_pn_src #(
    .LFSR_W (LFSR_W),
    .DATA_W (DATA_W),
    .TAP    (TAP),
    .SEED   (SEED)
  ) u_pn (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_seed (load_seed),
    .advance   (pn_adv),
    .word      (pn_word)
  );

  assign core_v[0] = core_a;
  assign core_v[1] = core_b;

  // Injection point per channel; odd channels take the inverted word
  for (genvar ch = 0; ch < NCH; ch++) begin : g_inj
    logic [DATA_W-1:0] pat;
    if (ch % 2 == 0) begin : g_true
      assign pat = pn_word;
    end else begin : g_inv
      assign pat = ~pn_word;
    end
    assign feed_v[ch] = (busy && sel_q[ch]) ? pat : core_v[ch];
  end

  assign feed_a = feed_v[0];
  assign feed_b = feed_v[1];

  bist_misr #(
    .SIG_W  (SIG_W),
    .DATA_W (DATA_W),
    .POLY   (POLY)
  ) u_misr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (accept),
    .upd    (upd),
    .use_a  (sel_q[0]),
    .use_b  (sel_q[1]),
    .din_a  (ret_a),
    .din_b  (ret_b),
    .sig    (sig),
    .sig_nx (sig_nx)
  );

  assign sig_lo = sig[7:0];
  assign sig_hi = sig[15:8];

endmodule

// File: rtl/dp_bist_ctrl_chk.sv
module dp_bist_ctrl_chk #(
  parameter int unsigned DATA_W  = 14,
  parameter int unsigned RUN_LEN = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              ret_valid,
  input logic              busy,
  input logic              done,
  input logic              last_upd,
  input logic [1:0]        sel_q,
  input logic [DATA_W-1:0] core_a,
  input logic [DATA_W-1:0] core_b,
  input logic [DATA_W-1:0] feed_a,
  input logic [DATA_W-1:0] feed_b,
  input logic [7:0]        sig_lo,
  input logic [7:0]        sig_hi
);

  // Independent count of update cycles in the current run
  int unsigned upd_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                upd_seen <= 0;
    else if (start && !busy)   upd_seen <= 0;
    else if (busy && ret_valid) upd_seen <= upd_seen + 1;
  end

  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_run_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (upd_seen == RUN_LEN) && done);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy && !done && sig_lo == 8'h00 && sig_hi == 8'h00);

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_upd) |=> busy);

  assert_sig_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sig_lo) && $stable(sig_hi));

  assert_idle_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (feed_a == core_a) && (feed_b == core_b));

  assert_sel_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(sel_q));

endmodule

bind dp_bist_ctrl dp_bist_ctrl_chk #(.DATA_W(DATA_W), .RUN_LEN(RUN_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .ret_valid (ret_valid),
  .busy      (busy),
  .done      (done),
  .last_upd  (last_upd),
  .sel_q     (sel_q),
  .core_a    (core_a),
  .core_b    (core_b),
  .feed_a    (feed_a),
  .feed_b    (feed_b),
  .sig_lo    (sig_lo),
  .sig_hi    (sig_hi)
);

// File: tb/sim_dp_bist_ctrl.sv
module sim_dp_bist_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        keep_state = 1'b0;
  logic [1:0]  chan_sel = 2'b00;
  logic        smp_valid = 1'b0;
  logic [13:0] core_a = '0, core_b = '0;
  logic [13:0] feed_a, feed_b;
  logic        ret_valid = 1'b0;
  logic [13:0] ret_a = '0, ret_b = '0;
  logic        busy, done;
  logic [7:0]  sig_lo, sig_hi;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dp_bist_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .keep_state(keep_state),
    .chan_sel(chan_sel), .smp_valid(smp_valid), .core_a(core_a), .core_b(core_b),
    .feed_a(feed_a), .feed_b(feed_b), .ret_valid(ret_valid), .ret_a(ret_a),
    .ret_b(ret_b), .busy(busy), .done(done), .sig_lo(sig_lo), .sig_hi(sig_hi)
  );

  // Behavioural reference state
  int m_busy = 0, m_done = 0, m_cnt = 0, m_sig = 0, m_sel = 0;
  int m_pn = 'h92;
  int pipe_a[$], pipe_b[$], pipe_v[$];

  function automatic int pn_word_m(int s);
    int w = 0;
    for (int k = 0; k < 14; k++) begin
      int fb = ((s >> 8) ^ (s >> 4)) & 1;
      s = ((s << 1) | fb) & 'h1FF;
      w = (w << 1) | fb;
    end
    return w;
  endfunction

  function automatic int pn_next_m(int s);
    for (int k = 0; k < 14; k++) s = ((s << 1) | (((s >> 8) ^ (s >> 4)) & 1)) & 'h1FF;
    return s;
  endfunction

  function automatic int sig_m(int s, int d);
    int top = (s >> 15) & 1;
    s = (s << 1) & 'hFFFF;
    if (top != 0) s = s ^ 'h1021;
    return s ^ d;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare, advance the model
  task automatic cycle(bit st, int vrate);
    int ea, eb;
    @(negedge clk);
    start     = st;
    smp_valid = (($urandom % 100) < vrate);
    core_a    = 14'($urandom);
    core_b    = 14'($urandom);
    ret_a     = 14'(pipe_a.pop_front());
    ret_b     = 14'(pipe_b.pop_front());
    ret_valid = pipe_v.pop_front() != 0;
    #1;
    ea = (m_busy != 0 && (m_sel & 1) != 0) ? pn_word_m(m_pn) : int'(core_a);
    eb = (m_busy != 0 && (m_sel & 2) != 0) ? (~pn_word_m(m_pn)) & 'h3FFF : int'(core_b);
    check("R3,R4,R5,R10 feed_a", int'(feed_a), ea);
    check("R3,R4,R5,R10 feed_b", int'(feed_b), eb);
    check("R2,R7,R8 busy", int'(busy), m_busy);
    check("R7 done", int'(done), m_done);
    check("R6,R9 sig_lo", int'(sig_lo), m_sig & 'hFF);
    check("R6,R9 sig_hi", int'(sig_hi), (m_sig >> 8) & 'hFF);
    pipe_a.push_back(ea);
    pipe_b.push_back(eb);
    pipe_v.push_back(int'(smp_valid));
    if (st && m_busy == 0) begin
      m_busy = 1; m_done = 0; m_cnt = 0; m_sig = 0; m_sel = int'(chan_sel);
      if (!keep_state) m_pn = 'h92;
    end else if (m_busy != 0) begin
      if (smp_valid) m_pn = pn_next_m(m_pn);
      if (ret_valid) begin
        if ((m_sel & 1) != 0) m_sig = sig_m(m_sig, int'(ret_a));
        if ((m_sel & 2) != 0) m_sig = sig_m(m_sig, int'(ret_b));
        m_cnt++;
        if (m_cnt == 512) begin m_busy = 0; m_done = 1; end
      end
    end
  endtask

  task automatic run(int sel, bit keep, bit noisy);
    chan_sel   = 2'(sel);
    keep_state = keep;
    cycle(1'b1, 75);
    while (m_busy != 0) begin
      bit extra = noisy && (($urandom % 50) == 0);
      if (noisy && ($urandom % 40) == 0) chan_sel = 2'($urandom);  // R10 stimulus
      cycle(extra, 75);  // extra start while busy exercises R8
    end
  endtask

  initial begin
    repeat (2) begin pipe_a.push_back(0); pipe_b.push_back(0); pipe_v.push_back(0); end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 sig", int'({sig_hi, sig_lo}), 0);
    check("R1 feed_a", int'(feed_a), int'(core_a));
    repeat (5) cycle(1'b0, 75);

    run(1, 1'b0, 1'b1);              // A only, reseeded
    repeat (30) cycle(1'b0, 75);     // R9 hold
    run(2, 1'b1, 1'b1);              // B only, continue
    repeat (20) cycle(1'b0, 60);
    run(3, 1'b1, 1'b0);              // both, continue
    run(3, 1'b0, 1'b1);              // back-to-back, both, reseeded
    repeat (10) cycle(1'b0, 90);
    run(1, 1'b1, 1'b0);
    repeat (25) cycle(1'b0, 75);
    // R9: explicit byte split against the model after the last run
    check("R9 sig_lo final", int'(sig_lo), m_sig & 'hFF);
    check("R7 done final", int'(done), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R7 watchdog: act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule